// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block serves a TLB miss. It turns a 32-bit virtual address into a physical address by reading an in-memory page table hierarchy. The walk starts at a context table entry, which is picked by a context table pointer and a context number. From there it passes through up to three directory levels. A leaf entry may appear at the first, second or third level, which gives regions of 16 MiB, 256 KiB or 4 KiB. The walker makes its memory accesses one 32-bit word at a time over a simple request/acknowledge port.

When the walk reaches a leaf, the block returns the physical address, the leaf level, the leaf's access field and its modified bit. A separate block then checks permissions against those values. Before it reports completion, the walker sets the leaf's referenced bit. On a write it also sets the modified bit, and it stores the entry back only if that changed it. A walk that meets an invalid entry, a reserved entry or an entry of the wrong kind ends with a fault code. When translation is disabled, the address passes through untouched in one cycle with full read and write rights, and no memory access is made.

The block handles one request at a time. `busy` is high for the whole walk, and any request that arrives during a walk is dropped.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is asserted and after it, `busy`, `done`, `fault` and `mem_req` are low.
- R2: With `xlat_en` low, an accepted request raises `done` on the next clock edge with `res_pa` equal to the zero-extended virtual address and `res_bypass` high. No memory access is made and `busy` stays low.
- R3: The first read of a walk goes to address `ctx_ptr*16 + ctx_id*4`.
- R4: The entry type is held in bits 1:0 of each word: 0 invalid, 1 descriptor, 2 leaf, 3 reserved. A descriptor gives the next table base `(entry[31:2])*64`. The next read goes to that base plus 4 times the index. The index is virtual address bits 31:24 for level 1, bits 23:18 for level 2 and bits 17:12 for level 3.
- R5: An invalid entry at any level ends the walk with a one-cycle `fault` pulse and `fault_type` = 1.
- R6: A reserved entry, a leaf in the context table or a descriptor at level 3 ends the walk with `fault_type` = 4.
- R7: A leaf gives `res_pa = {entry[31:8], 12'b0} + offset`. The offset is virtual address bits 23:0 at level 1, bits 17:0 at level 2 and bits 11:0 at level 3. `res_level` gives the leaf level (1 to 3) and `res_bypass` is low.
- R8: Bit 5 of the leaf (referenced) is always set, and on a write bit 6 (modified) is also set. The updated word is written once to the leaf's address only when it differs from the word read. Otherwise no write is made.
- R9: `busy` is high from acceptance until the cycle of the `done` or `fault` pulse. `done` and `fault` never pulse together. A request presented while `busy` is ignored.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until the cycle in which `mem_ack` is sampled high.
- R11: On `done`, `res_acc` is leaf bits 4:2 and `res_mod` is the modified bit after the update. `res_kind` is `{write, fetch, supervisor}`, where supervisor means `req_user` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| ctx_ptr | input | 32 | Context table pointer (byte address / 16) |
| ctx_id | input | CTX_W | Current context number |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_user | input | 1 | Request is from user mode |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PA_W | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done | output | 1 | One-cycle translation-complete pulse |
| fault | output | 1 | One-cycle walk-fault pulse |
| fault_type | output | 3 | Fault code (1 invalid, 4 wrong kind or reserved) |
| res_pa | output | PA_W | Physical address |
| res_level | output | 2 | Leaf level, 0 for pass-through |
| res_acc | output | 3 | Leaf access field |
| res_mod | output | 1 | Leaf modified bit after update |
| res_bypass | output | 1 | Result came from pass-through |
| res_kind | output | 3 | Access type code for the permission block |

## Verification
The assertions check every cycle that the memory request holds steady until acknowledged, and that `busy` falls only together with a `done` or `fault` pulse. They also check that the two pulses never coincide, that every write-back carries the referenced bit, that fault codes take only the two legal values, and that a pass-through completes without having been busy. The bench checks the rest against a walk model of its own. That includes the exact sequence of entry addresses, the fault code for each malformed-table shape and the physical address for each leaf size. It also covers whether a write-back happens and with what word, that a request issued mid-walk is dropped, and the one-cycle pass-through result.

// File: rtl/pgw_pkg.sv
// Shared constants, entry layout and walk types for the page table walker.
// Assumes 32-bit table words and a 32-bit virtual address with 4 KiB base pages.
package pgw_pkg;
    localparam int VA_W     = 32;
    localparam int ENT_W    = 32;
    localparam int PG_SHIFT = 12;
    localparam int ACC_LSB  = 2;
    localparam int REF_BIT  = 5;
    localparam int MOD_BIT  = 6;
    localparam int PPN_LSB  = 8;

    localparam logic [2:0] FLT_INVALID = 3'd1;
    localparam logic [2:0] FLT_KIND    = 3'd4;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_DESC    = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        ACT_NEXT  = 2'd0,
        ACT_LEAF  = 2'd1,
        ACT_FAULT = 2'd2
    } walk_act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } walk_st_e;

    // Top bit of the table index used at directory level lvl (1..3).
    function automatic int idx_hi(input int lvl);
        return (lvl == 1) ? 31 : (lvl == 2) ? 23 : 17;
    endfunction

    // Bottom bit of the table index used at directory level lvl (1..3).
    function automatic int idx_lo(input int lvl);
        return (lvl == 1) ? 24 : (lvl == 2) ? 18 : 12;
    endfunction
endpackage

// File: rtl/pgw_addr_gen.sv
// Entry address generator: gives the byte address of the table word
// read at walk level lvl (0 = context table, 1..3 = directory levels).
// Assumes tbl_base already holds the byte base of the current table.
module pgw_addr_gen
    import pgw_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic [1:0]              lvl,
    input  logic [31:0]             ctx_ptr,
    input  logic [CTX_W-1:0]        ctx_id,
    input  logic [PA_W-1:0]         tbl_base,
    input  logic [VA_W-1:PG_SHIFT]  vpn,
    output logic [PA_W-1:0]         ent_addr
);
    logic [PA_W-1:0] cand [4];

    // Context entry: pointer scaled by 16 plus context number scaled by 4.
    assign cand[0] = PA_W'({ctx_ptr, 4'b0000}) + PA_W'({ctx_id, 2'b00});

    // One candidate per directory level, each with its own index field.
    for (genvar g = 1; g < 4; g++) begin : g_lvl
        localparam int HI = idx_hi(g);
        localparam int LO = idx_lo(g);
        assign cand[g] = tbl_base + PA_W'({vpn[HI:LO], 2'b00});
    end

    assign ent_addr = cand[lvl];
endmodule

// File: rtl/pgw_entry_decode.sv
// Entry classifier: decides whether a fetched word continues the walk,
// ends it at a leaf, or faults, and derives the next table base.
// Assumes lvl is the level the word was read from.
module pgw_entry_decode
    import pgw_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [1:0]       lvl,
    input  logic [ENT_W-1:0] entry,
    output walk_act_e        act,
    output logic [2:0]       flt_code,
    output logic [PA_W-1:0]  nxt_base
);
    ent_kind_e kind;
    assign kind = ent_kind_e'(entry[1:0]);

    // Descriptor payload without type bits, scaled by 64 to a byte base.
    assign nxt_base = PA_W'({entry[ENT_W-1:2], 6'b000000});

    // Classify the entry against the level it came from.
    always_comb begin
        act      = ACT_FAULT;
        flt_code = FLT_KIND;
        unique case (kind)
            ET_INVALID: flt_code = FLT_INVALID;
            ET_RSVD:    flt_code = FLT_KIND;
            ET_DESC: begin
                if (lvl != 2'd3) act = ACT_NEXT;
            end
            ET_LEAF: begin
                if (lvl != 2'd0) act = ACT_LEAF;
            end
        endcase
    end
endmodule

// File: rtl/pgw_leaf_update.sv
// Leaf handler: builds the physical address for the leaf's region size
// and the entry with referenced/modified bits updated.
// Assumes lvl is 1..3 whenever the result is used.
module pgw_leaf_update
    import pgw_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_write,
    input  logic [1:0]       lvl,
    input  logic [VA_W-1:0]  vaddr,
    output logic [ENT_W-1:0] new_entry,
    output logic             need_wb,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] offs [4];

    assign offs[0] = '0;
    // Offset width shrinks with depth: 24, 18 and 12 bits.
    for (genvar g = 1; g < 4; g++) begin : g_off
        localparam int OB = idx_lo(g);
        assign offs[g] = PA_W'(vaddr[OB-1:0]);
    end

    assign phys = PA_W'({entry[ENT_W-1:PPN_LSB], 12'h000}) + offs[lvl];

    // Mark referenced always, modified on writes; flag a store-back on change.
    always_comb begin
        new_entry          = entry;
        new_entry[REF_BIT] = 1'b1;
        if (is_write) new_entry[MOD_BIT] = 1'b1;
        need_wb = (new_entry != entry);
    end
endmodule

// File: rtl/pgwalk_top.sv
// Three-level page table walker. Accepts one translation request at a time,
// reads the context entry and up to three directory entries, updates the
// leaf's referenced/modified bits and reports a physical address or a fault.
// Assumes memory responds with a one-cycle mem_ack and holds data with it.
module pgwalk_top
    import pgw_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic [31:0]       ctx_ptr,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_user,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              done,
    output logic              fault,
    output logic [2:0]        fault_type,
    output logic [PA_W-1:0]   res_pa,
    output logic [1:0]        res_level,
    output logic [2:0]        res_acc,
    output logic              res_mod,
    output logic              res_bypass,
    output logic [2:0]        res_kind
);
    walk_st_e          st_q;
    logic [1:0]        lvl_q;
    logic [PA_W-1:0]   addr_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [ENT_W-1:0]  wdata_q;

    logic [1:0]        gen_lvl;
    logic [VA_W-1:0]   gen_va;
    logic [PA_W-1:0]   gen_addr;
    walk_act_e         act;
    logic [2:0]        flt_code;
    logic [PA_W-1:0]   nxt_base;
    logic [ENT_W-1:0]  upd_entry;
    logic              upd_wb;
    logic [PA_W-1:0]   upd_pa;

    // Address source: context entry when idle, next level while reading.
    assign gen_lvl = (st_q == ST_IDLE) ? 2'd0 : lvl_q + 2'd1;
    assign gen_va  = (st_q == ST_IDLE) ? req_vaddr : va_q;

    pgw_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
        .lvl(gen_lvl), .ctx_ptr(ctx_ptr), .ctx_id(ctx_id),
        .tbl_base(nxt_base), .vpn(gen_va[VA_W-1:PG_SHIFT]), .ent_addr(gen_addr)
    );

    pgw_entry_decode #(.PA_W(PA_W)) u_dec (
        .lvl(lvl_q), .entry(mem_rdata), .act(act),
        .flt_code(flt_code), .nxt_base(nxt_base)
    );

    pgw_leaf_update #(.PA_W(PA_W)) u_leaf (
        .entry(mem_rdata), .is_write(wr_q), .lvl(lvl_q), .vaddr(va_q),
        .new_entry(upd_entry), .need_wb(upd_wb), .phys(upd_pa)
    );

    // Memory port is driven straight from walk state and held registers.
    assign busy      = (st_q != ST_IDLE);
    assign mem_req   = (st_q != ST_IDLE);
    assign mem_we    = (st_q == ST_WRITE);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    // Walk sequencer: accept, read levels, optional store-back, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            lvl_q      <= '0;
            addr_q     <= '0;
            va_q       <= '0;
            wr_q       <= 1'b0;
            wdata_q    <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_type <= '0;
            res_pa     <= '0;
            res_level  <= '0;
            res_acc    <= '0;
            res_mod    <= 1'b0;
            res_bypass <= 1'b0;
            res_kind   <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q     <= req_vaddr;
                        wr_q     <= req_write;
                        res_kind <= {req_write, req_fetch, ~req_user};
                        if (!xlat_en) begin
                            done       <= 1'b1;
                            res_pa     <= PA_W'(req_vaddr);
                            res_bypass <= 1'b1;
                            res_level  <= 2'd0;
                            res_acc    <= '0;
                            res_mod    <= 1'b0;
                        end else begin
                            st_q       <= ST_READ;
                            lvl_q      <= 2'd0;
                            addr_q     <= gen_addr;
                            res_bypass <= 1'b0;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        unique case (act)
                            ACT_NEXT: begin
                                lvl_q  <= lvl_q + 2'd1;
                                addr_q <= gen_addr;
                            end
                            ACT_LEAF: begin
                                res_pa    <= upd_pa;
                                res_level <= lvl_q;
                                res_acc   <= mem_rdata[ACC_LSB+2:ACC_LSB];
                                res_mod   <= upd_entry[MOD_BIT];
                                wdata_q   <= upd_entry;
                                if (upd_wb) begin
                                    st_q <= ST_WRITE;
                                end else begin
                                    st_q <= ST_IDLE;
                                    done <= 1'b1;
                                end
                            end
                            default: begin
                                st_q       <= ST_IDLE;
                                fault      <= 1'b1;
                                fault_type <= flt_code;
                            end
                        endcase
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10: an unacknowledged access stays put.
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: the walk ends only with a result pulse.
    a_r9_busy_ends_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || fault));

    // R9: completion and fault are exclusive.
    a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R8: any store-back carries the referenced bit.
    a_r8_wb_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[REF_BIT]);

    // R5 and R6: only the two fault codes exist.
    a_r6_fault_codes: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_type == FLT_INVALID || fault_type == FLT_KIND));

    // R2: a pass-through result never follows a busy cycle.
    a_r2_bypass_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_bypass) |-> !$past(busy));
endmodule

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
    localparam int PA_W  = 36;
    localparam int CTX_W = 8;
    localparam int MEM_WORDS = 1024;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xlat_en = 1'b1;
    logic [31:0]       ctx_ptr = '0;
    logic [CTX_W-1:0]  ctx_id = '0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_vaddr = '0;
    logic              req_write = 1'b0;
    logic              req_fetch = 1'b0;
    logic              req_user = 1'b0;
    logic              busy, mem_req, mem_we, done, fault, res_mod, res_bypass;
    logic [PA_W-1:0]   mem_addr, res_pa;
    logic [31:0]       mem_wdata;
    logic              mem_ack = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic [2:0]        fault_type, res_acc, res_kind;
    logic [1:0]        res_level;

    pgwalk_top #(.PA_W(PA_W), .CTX_W(CTX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .ctx_ptr(ctx_ptr), .ctx_id(ctx_id),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .req_fetch(req_fetch), .req_user(req_user), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_type(fault_type), .res_pa(res_pa), .res_level(res_level),
        .res_acc(res_acc), .res_mod(res_mod), .res_bypass(res_bypass), .res_kind(res_kind)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0]     mem [0:MEM_WORDS-1];
    logic [PA_W-1:0] rd_log [0:7];
    int              rd_cnt = 0;
    int              wr_cnt = 0;
    logic [PA_W-1:0] wr_a;
    logic [31:0]     wr_d;

    bit              e_flt, e_wb, e_mod;
    logic [2:0]      e_code, e_acc;
    logic [PA_W-1:0] e_pa, e_wba;
    logic [1:0]      e_lvl;
    int              e_nrd;
    logic [PA_W-1:0] e_rd [0:3];
    logic [31:0]     e_wbd;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mrd(input logic [PA_W-1:0] a);
        return (a < PA_W'(MEM_WORDS * 4)) ? mem[a[11:2]] : 32'h0;
    endfunction

    // Memory responder: random 0..2 cycle latency, one-cycle ack, logs accesses (R10 hold check).
    initial begin
        int lat;
        bit waiting;
        logic [PA_W-1:0] first_a;
        lat = 0;
        waiting = 1'b0;
        first_a = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_ack = 1'b0;
                waiting = 1'b0;
            end else if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!waiting) begin
                    waiting = 1'b1;
                    first_a = mem_addr;
                    lat = int'($urandom % 3);
                end
                if (lat == 0) begin
                    chk(mem_addr == first_a, "R10", "address held until ack", 64'(mem_addr), 64'(first_a));
                    if (mem_we) begin
                        if (mem_addr < PA_W'(MEM_WORDS * 4)) mem[mem_addr[11:2]] = mem_wdata;
                        wr_cnt++;
                        wr_a = mem_addr;
                        wr_d = mem_wdata;
                    end else begin
                        mem_rdata = mrd(mem_addr);
                        if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
                        rd_cnt++;
                    end
                    mem_ack = 1'b1;
                    waiting = 1'b0;
                end else begin
                    lat--;
                end
            end
        end
    end

    // Bench walk model built from the requirements.
    task automatic model(input logic [31:0] va, input bit wr);
        logic [PA_W-1:0] a;
        logic [31:0] e, ne, off;
        logic [7:0] idx;
        bit fin;
        a = PA_W'({ctx_ptr, 4'b0}) + PA_W'(ctx_id) * 4;
        e_nrd = 0; e_wb = 0; e_flt = 0; fin = 0; e_code = 0;
        for (int l = 0; l < 4; l++) begin
            if (!fin) begin
                e_rd[l] = a;
                e_nrd++;
                e = mrd(a);
                case (e[1:0])
                    2'd0: begin e_flt = 1; e_code = 3'd1; fin = 1; end
                    2'd3: begin e_flt = 1; e_code = 3'd4; fin = 1; end
                    2'd1: begin
                        if (l == 3) begin e_flt = 1; e_code = 3'd4; fin = 1; end
                        else begin
                            idx = (l == 0) ? va[31:24] : (l == 1) ? {2'b0, va[23:18]} : {2'b0, va[17:12]};
                            a = PA_W'({e[31:2], 6'b0}) + PA_W'(idx) * 4;
                        end
                    end
                    default: begin
                        if (l == 0) begin e_flt = 1; e_code = 3'd4; fin = 1; end
                        else begin
                            off = (l == 1) ? {8'h0, va[23:0]} : (l == 2) ? {14'h0, va[17:0]} : {20'h0, va[11:0]};
                            e_pa = PA_W'({e[31:8], 12'h000}) + PA_W'(off);
                            e_lvl = 2'(l);
                            e_acc = e[4:2];
                            ne = e | 32'h20 | (wr ? 32'h40 : 32'h0);
                            e_mod = ne[6];
                            e_wb = (ne != e);
                            e_wba = a;
                            e_wbd = ne;
                            fin = 1;
                        end
                    end
                endcase
            end
        end
    endtask

    // Issue one walk, optionally with a stray request while busy, and check it.
    task automatic run_walk(input logic [31:0] va, input bit wr, input bit fe,
                            input bit us, input bit stray);
        int t;
        string tag;
        logic [2:0] kind;
        model(va, wr);
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_fetch = fe; req_user = us; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (stray && busy && !done && !fault) begin
            req_valid = 1'b1; req_vaddr = ~va; req_write = ~wr;
        end
        t = 0;
        while (!(done || fault) && t < 200) begin
            @(negedge clk);
            req_valid = 1'b0;
            t++;
        end
        chk(t < 200, "R9", "walk finished", 64'(t), 64'd0);
        tag = e_flt ? ((e_code == 3'd1) ? "R5" : "R6") : "R7";
        chk(fault == e_flt && done == !e_flt, tag, "outcome fault", 64'(fault), 64'(e_flt));
        kind = {wr, fe, ~us};
        if (e_flt) begin
            chk(fault_type == e_code, tag, "fault_type", 64'(fault_type), 64'(e_code));
        end else begin
            chk(res_pa == e_pa, "R7", "physical address", 64'(res_pa), 64'(e_pa));
            chk(res_level == e_lvl, "R7", "leaf level", 64'(res_level), 64'(e_lvl));
            chk(res_bypass == 1'b0, "R7", "bypass low", 64'(res_bypass), 64'd0);
            chk(res_acc == e_acc, "R11", "access field", 64'(res_acc), 64'(e_acc));
            chk(res_mod == e_mod, "R11", "modified out", 64'(res_mod), 64'(e_mod));
            chk(res_kind == kind, "R11", "kind code", 64'(res_kind), 64'(kind));
        end
        chk(rd_cnt == e_nrd, "R3", "read count", 64'(rd_cnt), 64'(e_nrd));
        for (int i = 0; i < 4; i++) begin
            if (i < e_nrd && i < rd_cnt) begin
                if (i == 0) chk(rd_log[i] == e_rd[i], "R3", "context entry address", 64'(rd_log[i]), 64'(e_rd[i]));
                else        chk(rd_log[i] == e_rd[i], "R4", "level entry address", 64'(rd_log[i]), 64'(e_rd[i]));
            end
        end
        chk(wr_cnt == (e_wb ? 1 : 0), "R8", "write-back count", 64'(wr_cnt), 64'(e_wb));
        if (e_wb && wr_cnt == 1) begin
            chk(wr_a == e_wba, "R8", "write-back address", 64'(wr_a), 64'(e_wba));
            chk(wr_d == e_wbd, "R8", "write-back data", 64'(wr_d), 64'(e_wbd));
        end
        if (stray) begin
            @(negedge clk);
            chk(busy == 1'b0, "R9", "stray request ignored", 64'(busy), 64'd0);
        end
    endtask

    // Fill the chain of entries a random address will touch.
    task automatic setup_chain(input logic [31:0] va);
        int r;
        logic [31:0] leaf;
        leaf = ($urandom & 32'hFFFF_FFFC) | 32'h2;
        r = int'($urandom % 10);
        mem[{2'b0, ctx_id}] = (r == 0) ? 32'h0 : (r == 1) ? 32'h3 : (r == 2) ? leaf : 32'h41;
        leaf = ($urandom & 32'hFFFF_FFFC) | 32'h2;
        r = int'($urandom % 10);
        mem[10'h100 + {2'b0, va[31:24]}] = (r == 0) ? 32'h0 : (r == 1) ? 32'h3 : (r < 4) ? leaf : 32'h81;
        leaf = ($urandom & 32'hFFFF_FFFC) | 32'h2;
        r = int'($urandom % 10);
        mem[10'h200 + {4'b0, va[23:18]}] = (r == 0) ? 32'h0 : (r == 1) ? 32'h3 : (r < 4) ? leaf : 32'h91;
        leaf = ($urandom & 32'hFFFF_FFFC) | 32'h2;
        r = int'($urandom % 10);
        mem[10'h240 + {4'b0, va[17:12]}] = (r == 0) ? 32'h0 : (r == 1) ? 32'h3 : (r == 2) ? 32'h81 : leaf;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] va;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "outputs idle in reset",
            64'({busy, done, fault, mem_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fault && !mem_req, "R1", "outputs idle after reset",
            64'({busy, done, fault, mem_req}), 64'd0);

        // R2: pass-through completes next edge without memory traffic.
        xlat_en = 1'b0;
        rd_cnt = 0; wr_cnt = 0;
        req_vaddr = 32'hDEAD_B123; req_write = 1'b1; req_fetch = 1'b0; req_user = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, "R2", "pass-through done next cycle", 64'(done), 64'd1);
        chk(res_pa == 36'h0_DEAD_B123, "R2", "pass-through address", 64'(res_pa), 64'h0_DEAD_B123);
        chk(res_bypass == 1'b1 && busy == 1'b0, "R2", "bypass flag, not busy", 64'({res_bypass, busy}), 64'h2);
        chk(res_kind == 3'b100, "R11", "pass-through kind", 64'(res_kind), 64'h4);
        repeat (3) @(negedge clk);
        chk(rd_cnt + wr_cnt == 0, "R2", "no memory access", 64'(rd_cnt + wr_cnt), 64'd0);
        xlat_en = 1'b1;

        // R3: nonzero context pointer and number (entry at byte 0x18); R8: no store-back when bits already set.
        ctx_ptr = 32'h1; ctx_id = 8'd2;
        mem[6] = 32'h41;
        mem[10'h100 + 10'h12] = 32'hABCD_E000 | 32'h60 | 32'h0C | 32'h2;
        run_walk(32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0);
        ctx_ptr = 32'h0; ctx_id = 8'd0;

        // R8: level-3 leaf, clean, write: modified set and stored back.
        mem[0] = 32'h41;
        mem[10'h100 + 10'h05] = 32'h81;
        mem[10'h200 + 10'h03] = 32'h91;
        mem[10'h240 + 10'h07] = 32'h0012_3400 | 32'h2;
        run_walk(32'h050C_7ABC, 1'b1, 1'b0, 1'b1, 1'b0);

        // R6: descriptor at level 3.
        mem[10'h240 + 10'h07] = 32'h81;
        run_walk(32'h050C_7ABC, 1'b0, 1'b1, 1'b1, 1'b0);

        // R9: stray request during a walk is dropped.
        mem[10'h240 + 10'h07] = 32'h0055_6600 | 32'h2;
        run_walk(32'h050C_7001, 1'b0, 1'b0, 1'b0, 1'b1);

        // Random walks over varied table shapes.
        for (int n = 0; n < 300; n++) begin
            va = $urandom;
            ctx_id = 8'($urandom);
            setup_chain(va);
            run_walk(va, 1'($urandom), 1'($urandom), 1'($urandom), (n % 17) == 0);
        end

        finish_run();
    end
endmodule